// File: doc/BRIEF.md
# Cartridge bank mapping register file

This block is the write-side register file of a game-cartridge address mapper. It watches a CPU write strobe with a 16-bit address and 8-bit data. It decodes each write into one of several register groups: eight 1 KB pattern-slot bank registers, four nametable-slot bank registers, three 8 KB program-window bank registers, two half-select enable flags and the load interface of a 15-bit interrupt counter.

For every pattern and nametable slot, the block presents two things: the stored bank number and a flag. The flag says whether the slot is served from internal RAM or from character ROM. For each program window it presents the bank index, scaled to the unit the program memory uses. The memories themselves, the video and CPU buses, and the counter's decrement logic all live outside the block.

The RAM/ROM decision for a pattern slot combines two inputs: the written value compared against a threshold, and an enable flag for that slot's half of the pattern space. The decision is taken when the slot is written. A later change to the enable flag does not affect a slot until that slot is written again.

Top module: `cart_bank_regs`

## Requirements
- R1: On reset every output is zero: all bank numbers, all RAM flags, the interrupt count and the interrupt enable. Both half-select enable flags are cleared, so a pattern write straight after reset maps to ROM whatever its value.
- R2: A write whose address bits 15:11 equal 0x10+k (k = 0..7, i.e. the 2 KB span starting at 0x8000+0x800*k) loads pattern slot k's bank (`pat_bank[8k+7:8k]`) with the data. The change is visible after the next rising clock edge.
- R3: For pattern slots 0..3, `pat_is_ram[k]` is set by the write when the low-half enable flag is 1 and the data is 0xE0 or above. Otherwise the write clears it. The value is held until the slot is written again.
- R4: Pattern slots 4..7 follow the rule of R3, but use the high-half enable flag.
- R5: A write whose address bits 15:11 equal 0x18+k (k = 0..3, spans from 0xC000) loads nametable slot k's bank with the data. It sets `nt_is_ram[k]` exactly when the data is 0xE0 or above.
- R6: A write whose address bits 15:11 equal 0x1C, 0x1D or 0x1E (spans from 0xE000, 0xE800, 0xF000) loads program window 0, 1 or 2 with data*2. The result is a 9-bit value at `prg_bank[9w+8:9w]`.
- R7: Only a write to exactly 0xE800 updates the enable flags, taking the low-half flag from data bit 6 and the high-half flag from data bit 7. Any other address in that span updates program window 1 only.
- R8: A write in 0x5000..0x57FF loads `irq_count[7:0]` from the data and leaves `irq_count[14:8]` and `irq_enable` unchanged.
- R9: A write in 0x5800..0x5FFF loads `irq_count[14:8]` from data bits 6:0 and `irq_enable` from data bit 7, and leaves `irq_count[7:0]` unchanged.
- R10: A write to an address outside every range above, or any cycle with `wr_en` low, leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | CPU write strobe, one write per cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| pat_bank | output | 64 | Eight pattern-slot bank numbers, slot k at bits 8k+7:8k |
| pat_is_ram | output | 8 | Pattern slot k served from internal RAM |
| nt_bank | output | 32 | Four nametable-slot bank numbers, slot k at bits 8k+7:8k |
| nt_is_ram | output | 4 | Nametable slot k served from internal RAM |
| prg_bank | output | 27 | Three program-window indices, window w at bits 9w+8:9w |
| irq_count | output | 15 | Loaded interrupt counter value |
| irq_enable | output | 1 | Interrupt enable |

## Verification
Pattern writes are issued with the enable flags off, both on, and only the low one on, each at values just below, at and above 0xE0. This separates a threshold-only rule from a flag-only rule, and a correct half selection from one that swaps the halves. A write to 0xE801 followed by a pattern write tells an exact flag-address match from a span match. Writes at the first and last byte of spans check the span decode. Interleaved low and high counter loads show that each half keeps the other half's bits. Writes just outside the decoded spans, and a strobe-low cycle, must leave previously loaded values in place.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
   // address span granularity: one register per 2 KB of address space
   localparam int SPAN_LSB      = 11;
   // span indices (address bits 15:11) of the first register of each group
   localparam int PAT_SPAN0     = 'h10;
   localparam int NT_SPAN0      = 'h18;
   localparam int PRG_SPAN0     = 'h1C;
   localparam int IRQ_LO_SPAN   = 'h0A;
   localparam int IRQ_HI_SPAN   = 'h0B;
   localparam int FLAG_ADDR     = 'hE800;

   typedef struct packed {
      logic hi;
      logic lo;
   } half_en_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode import cbr_pkg::*; #(
   parameter int ADDR_W = 16,
   parameter int N_PAT  = 8,
   parameter int N_NT   = 4,
   parameter int N_PRG  = 3
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [N_PAT-1:0]  pat_we,
   output logic [N_NT-1:0]   nt_we,
   output logic [N_PRG-1:0]  prg_we,
   output logic              irq_lo_we,
   output logic              irq_hi_we,
   output logic              flag_we
);
   localparam int SPAN_W = ADDR_W - SPAN_LSB;

   if (SPAN_W < 1) begin : g_bad_w
      $error("cbr_decode: ADDR_W too small for span decode");
   end
   if (PAT_SPAN0 + N_PAT > NT_SPAN0 || NT_SPAN0 + N_NT > PRG_SPAN0) begin : g_bad_map
      $error("cbr_decode: register groups overlap");
   end

   logic [SPAN_W-1:0] span;
   assign span = addr[ADDR_W-1:SPAN_LSB];

   for (genvar k = 0; k < N_PAT; k++) begin : g_pat
      assign pat_we[k] = wr_en && (span == SPAN_W'(PAT_SPAN0 + k));
   end
   for (genvar k = 0; k < N_NT; k++) begin : g_nt
      assign nt_we[k] = wr_en && (span == SPAN_W'(NT_SPAN0 + k));
   end
   for (genvar w = 0; w < N_PRG; w++) begin : g_prg
      assign prg_we[w] = wr_en && (span == SPAN_W'(PRG_SPAN0 + w));
   end

   assign irq_lo_we = wr_en && (span == SPAN_W'(IRQ_LO_SPAN));
   assign irq_hi_we = wr_en && (span == SPAN_W'(IRQ_HI_SPAN));
   assign flag_we   = wr_en && (addr == ADDR_W'(FLAG_ADDR));
endmodule

// File: rtl/cbr_slot_reg.sv
module cbr_slot_reg #(
   parameter int          DATA_W  = 8,
   parameter logic [7:0]  RAM_MIN = 8'hE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] data,
   input  logic              gate,
   output logic [DATA_W-1:0] bank,
   output logic              is_ram
);
   localparam logic [DATA_W-1:0] THRESH = DATA_W'(RAM_MIN);

   if (DATA_W < 8) begin : g_bad_w
      $error("cbr_slot_reg: DATA_W must hold the RAM threshold");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank   <= '0;
         is_ram <= 1'b0;
      end else if (we) begin
         bank   <= data;
         is_ram <= gate && (data >= THRESH);
      end
   end
endmodule

// File: rtl/cbr_irq_load.sv
module cbr_irq_load #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [DATA_W-1:0] data,
   output logic [CNT_W-1:0]  count,
   output logic              enable
);
   localparam int HI_W = CNT_W - DATA_W;

   if (HI_W < 1 || HI_W > DATA_W - 1) begin : g_bad_w
      $error("cbr_irq_load: upper count part must fit below the enable bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         enable <= 1'b0;
      end else if (lo_we) begin
         count[DATA_W-1:0] <= data;
      end else if (hi_we) begin
         count[CNT_W-1:DATA_W] <= data[HI_W-1:0];
         enable                <= data[DATA_W-1];
      end
   end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs import cbr_pkg::*; #(
   parameter int         ADDR_W    = 16,
   parameter int         DATA_W    = 8,
   parameter int         N_PAT     = 8,
   parameter int         N_NT      = 4,
   parameter int         N_PRG     = 3,
   parameter int         PRG_SHIFT = 1,
   parameter int         CNT_W     = 15,
   parameter int         LO_EN_BIT = 6,
   parameter int         HI_EN_BIT = 7,
   parameter logic [7:0] RAM_MIN   = 8'hE0,
   localparam int        PRG_W     = DATA_W + PRG_SHIFT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [N_PAT*DATA_W-1:0] pat_bank,
   output logic [N_PAT-1:0]        pat_is_ram,
   output logic [N_NT*DATA_W-1:0]  nt_bank,
   output logic [N_NT-1:0]         nt_is_ram,
   output logic [N_PRG*PRG_W-1:0]  prg_bank,
   output logic [CNT_W-1:0]        irq_count,
   output logic                    irq_enable
);
   localparam int HALF = N_PAT / 2;

   if (N_PAT % 2 != 0) begin : g_bad_pat
      $error("cart_bank_regs: pattern slots must split into two halves");
   end
   if (LO_EN_BIT >= DATA_W || HI_EN_BIT >= DATA_W || LO_EN_BIT == HI_EN_BIT) begin : g_bad_bits
      $error("cart_bank_regs: enable bit positions invalid");
   end

   logic [N_PAT-1:0] pat_we;
   logic [N_NT-1:0]  nt_we;
   logic [N_PRG-1:0] prg_we;
   logic             irq_lo_we, irq_hi_we, flag_we;
   half_en_t         half_en;

   cbr_decode #(
      .ADDR_W(ADDR_W), .N_PAT(N_PAT), .N_NT(N_NT), .N_PRG(N_PRG)
   ) i_decode (
      .wr_en     (wr_en),
      .addr      (wr_addr),
      .pat_we    (pat_we),
      .nt_we     (nt_we),
      .prg_we    (prg_we),
      .irq_lo_we (irq_lo_we),
      .irq_hi_we (irq_hi_we),
      .flag_we   (flag_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_en <= '0;
      end else if (flag_we) begin
         half_en.lo <= wr_data[LO_EN_BIT];
         half_en.hi <= wr_data[HI_EN_BIT];
      end
   end

   for (genvar k = 0; k < N_PAT; k++) begin : g_pat
      logic gate;
      if (k < HALF) begin : g_low
         assign gate = half_en.lo;
      end else begin : g_high
         assign gate = half_en.hi;
      end
      cbr_slot_reg #(.DATA_W(DATA_W), .RAM_MIN(RAM_MIN)) i_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (pat_we[k]),
         .data   (wr_data),
         .gate   (gate),
         .bank   (pat_bank[k*DATA_W +: DATA_W]),
         .is_ram (pat_is_ram[k])
      );
   end

   for (genvar k = 0; k < N_NT; k++) begin : g_nt
      cbr_slot_reg #(.DATA_W(DATA_W), .RAM_MIN(RAM_MIN)) i_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (nt_we[k]),
         .data   (wr_data),
         .gate   (1'b1),
         .bank   (nt_bank[k*DATA_W +: DATA_W]),
         .is_ram (nt_is_ram[k])
      );
   end

   logic [PRG_W-1:0] prg_scaled;
   if (PRG_SHIFT == 0) begin : g_noscale
      assign prg_scaled = wr_data;
   end else begin : g_scale
      assign prg_scaled = {wr_data, {PRG_SHIFT{1'b0}}};
   end

   for (genvar w = 0; w < N_PRG; w++) begin : g_prg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prg_bank[w*PRG_W +: PRG_W] <= '0;
         end else if (prg_we[w]) begin
            prg_bank[w*PRG_W +: PRG_W] <= prg_scaled;
         end
      end
   end

   cbr_irq_load #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_we  (irq_lo_we),
      .hi_we  (irq_hi_we),
      .data   (wr_data),
      .count  (irq_count),
      .enable (irq_enable)
   );
endmodule

// File: rtl/cart_bank_regs_chk.sv
module cart_bank_regs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_addr,
   input logic [7:0]  wr_data,
   input logic [63:0] pat_bank,
   input logic [7:0]  pat_is_ram,
   input logic [31:0] nt_bank,
   input logic [3:0]  nt_is_ram,
   input logic [26:0] prg_bank,
   input logic [14:0] irq_count,
   input logic        irq_enable
);
   // R2
   pat_slot0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:11] == 5'h10) |=> pat_bank[7:0] == $past(wr_data));

   // R5
   nt_ram_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:11] == 5'h18) |=> nt_is_ram[0] == ($past(wr_data) >= 8'hE0));

   // R6
   prg_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:11] == 5'h1C) |=> prg_bank[8:0] == {$past(wr_data), 1'b0});

   // R7
   flag_addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:11] == 5'h1D) |=> $stable(pat_is_ram) && $stable(pat_bank));

   // R8
   irq_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:11] == 5'h0A) |=>
         irq_count[14:8] == $past(irq_count[14:8]) && $stable(irq_enable));

   // R9
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:11] == 5'h0B) |=>
         irq_enable == $past(wr_data[7]) && irq_count[7:0] == $past(irq_count[7:0]));

   // R10
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pat_bank) && $stable(pat_is_ram) && $stable(nt_bank)
                 && $stable(nt_is_ram) && $stable(prg_bank) && $stable(irq_count)
                 && $stable(irq_enable));
endmodule

bind cart_bank_regs cart_bank_regs_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .pat_bank   (pat_bank),
   .pat_is_ram (pat_is_ram),
   .nt_bank    (nt_bank),
   .nt_is_ram  (nt_is_ram),
   .prg_bank   (prg_bank),
   .irq_count  (irq_count),
   .irq_enable (irq_enable)
);

// File: tb/test_cart_bank_regs.sv
module test_cart_bank_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [63:0] pat_bank;
   logic [7:0]  pat_is_ram;
   logic [31:0] nt_bank;
   logic [3:0]  nt_is_ram;
   logic [26:0] prg_bank;
   logic [14:0] irq_count;
   logic        irq_enable;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   cart_bank_regs i_cart_bank_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pat_bank(pat_bank), .pat_is_ram(pat_is_ram), .nt_bank(nt_bank),
      .nt_is_ram(nt_is_ram), .prg_bank(prg_bank), .irq_count(irq_count),
      .irq_enable(irq_enable)
   );

   // vector fields: req(4) sel(4) addr(16) data(8) expected(16)
   // sel 0-7 pattern slot {ram,bank}; 8-11 nametable {ram,bank}; 12-14 program window; 15 {irq_enable,irq_count}
   localparam int NV = 27;
   localparam logic [47:0] VECS [NV] = '{
      {4'd3,  4'd0,  16'h8000, 8'hE5, 16'h00E5},  // R3 flags off
      {4'd2,  4'd1,  16'h8800, 8'h12, 16'h0012},  // R2
      {4'd2,  4'd3,  16'h9FFF, 8'h34, 16'h0034},  // R2 span end
      {4'd4,  4'd4,  16'hA000, 8'hF0, 16'h00F0},  // R4 flags off
      {4'd2,  4'd7,  16'hBC00, 8'h56, 16'h0056},  // R2
      {4'd6,  4'd13, 16'hE800, 8'hC0, 16'h0180},  // R6 and R7 both flags on
      {4'd3,  4'd0,  16'h8000, 8'hE0, 16'h01E0},  // R3 at threshold
      {4'd3,  4'd2,  16'h9000, 8'hDF, 16'h00DF},  // R3 below threshold
      {4'd4,  4'd7,  16'hB800, 8'hFF, 16'h01FF},  // R4
      {4'd7,  4'd13, 16'hE801, 8'h00, 16'h0000},  // R7 window only
      {4'd7,  4'd1,  16'h8800, 8'hE1, 16'h01E1},  // R7 flags kept
      {4'd7,  4'd13, 16'hE800, 8'h40, 16'h0080},  // R7 low flag only
      {4'd4,  4'd5,  16'hA800, 8'hE2, 16'h00E2},  // R4 high flag off
      {4'd3,  4'd0,  16'h8400, 8'hE3, 16'h01E3},  // R3 low flag on
      {4'd5,  4'd8,  16'hC000, 8'hDF, 16'h00DF},  // R5
      {4'd5,  4'd9,  16'hC800, 8'hE0, 16'h01E0},  // R5
      {4'd5,  4'd11, 16'hDFFF, 8'hFF, 16'h01FF},  // R5
      {4'd6,  4'd12, 16'hE000, 8'h7F, 16'h00FE},  // R6
      {4'd6,  4'd14, 16'hF7FF, 8'hFF, 16'h01FE},  // R6
      {4'd8,  4'd15, 16'h5000, 8'hAB, 16'h00AB},  // R8
      {4'd9,  4'd15, 16'h5FFF, 8'hFF, 16'hFFAB},  // R9
      {4'd8,  4'd15, 16'h57FF, 8'h01, 16'hFF01},  // R8
      {4'd9,  4'd15, 16'h5800, 8'h05, 16'h0501},  // R9
      {4'd10, 4'd14, 16'hF800, 8'h99, 16'h01FE},  // R10
      {4'd10, 4'd15, 16'h4FFF, 8'h99, 16'h0501},  // R10
      {4'd10, 4'd15, 16'h6000, 8'h99, 16'h0501},  // R10
      {4'd10, 4'd0,  16'h7FFF, 8'h99, 16'h01E3}   // R10
   };

   function automatic logic [15:0] observe(input logic [3:0] sel);
      int k;
      if (sel < 4'd8) begin
         k = int'(sel);
         return {7'b0, pat_is_ram[k], pat_bank[k*8 +: 8]};
      end else if (sel < 4'd12) begin
         k = int'(sel) - 8;
         return {7'b0, nt_is_ram[k], nt_bank[k*8 +: 8]};
      end else if (sel < 4'd15) begin
         k = int'(sel) - 12;
         return {7'b0, prg_bank[k*9 +: 9]};
      end
      return {irq_enable, irq_count};
   endfunction

   task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d got %h expected %h", req, got, exp);
      end
   endtask

   task automatic write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_all_zero();
      // R1
      check(1, {8'b0, pat_is_ram}, 16'h0);
      check(1, pat_bank[63:48] | pat_bank[47:32] | pat_bank[31:16] | pat_bank[15:0], 16'h0);
      check(1, nt_bank[31:16] | nt_bank[15:0] | {12'b0, nt_is_ram}, 16'h0);
      check(1, {5'b0, prg_bank[26:18] | prg_bank[17:9] | prg_bank[8:0]}, 16'h0);
      check(1, {irq_enable, irq_count}, 16'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all_zero();

      for (int i = 0; i < NV; i++) begin
         write(VECS[i][39:24], VECS[i][23:16]);
         check(int'(VECS[i][47:44]), observe(VECS[i][43:40]), VECS[i][15:0]);
      end

      // R10: strobe low at a decoded address has no effect
      @(negedge clk);
      wr_addr = 16'h8000; wr_data = 8'hAA;
      @(negedge clk);
      check(10, observe(4'd0), 16'h01E3);

      // R1: reset in mid-run clears everything, flags included
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all_zero();
      write(16'h8000, 8'hE7);
      check(1, observe(4'd0), 16'h00E7);
      write(16'hB000, 8'hF3);
      check(4, observe(4'd6), 16'h00F3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule